// File: doc/BRIEF.md
# ECC Fault Flag and Interrupt Controller

This block sits beside a memory array's error-correction decoder. On each array read it takes the decoder's single-bit and double-bit fault indications, together with the address and data of that read. It keeps two sticky status flags, one for single-bit faults and one for double-bit faults. It also holds one error-capture register that records the address and data of the first real fault. Three level interrupt lines come out: one for single-bit faults, one for double-bit faults, and one for a command-complete flag that an external sequencer supplies.

Software reaches the block through a small byte-wide register port. A control byte holds four bits: the command-complete interrupt enable, a control that ignores single-bit faults, and two fault-injection bits. Each injection bit makes every read raise its flag, so interrupt handlers can be tested without a faulty array. Injected faults never load the capture register. An enable byte holds the two fault interrupt enables. The status byte clears by writing 1 to a flag bit.

The read event input is a single-cycle strobe with no back-pressure. The block accepts one read every cycle and has no ready signal, because it only observes reads that already happened. Register reads are combinational from the select input.

Top module: `ecc_fault_ctrl`

## Requirements
- R1: The enable byte at select 1 holds the double-fault interrupt enable in bit 1 and the single-fault interrupt enable in bit 0. Bits 7..2 read as 0, and the byte resets to 0x00.
- R2: The control byte at select 0 holds the command-complete interrupt enable in bit 7, ignore-single in bit 4, force-double in bit 1 and force-single in bit 0. All other bits read 0, and the byte resets to 0x00. A force bit stays set across any number of reads until software writes 0 to it.
- R3: A read (rd_valid=1) with rd_sgl=1 and rd_dbl=0 sets the single flag (status byte at select 2, bit 0) when ignore-single is clear. With rd_valid=0 the fault inputs have no effect.
- R4: With ignore-single set, a real single-bit fault sets no flag, raises no interrupt and loads no capture.
- R5: A read with rd_dbl=1 sets the double flag (status bit 1). When rd_sgl=1 arrives on the same read, only the double fault is flagged and captured, and the single flag is unchanged.
- R6: With force-double set, every read sets the double flag. The capture register is not loaded unless a real fault occurs on that read.
- R7: With force-single set, every read sets the single flag, even when ignore-single is set. The capture register is not loaded unless a real reported fault occurs.
- R8: Flags are sticky and only reads set them. Writing 1 to a status bit clears that flag, and writing 0 has no effect. When a set and a clear hit the same cycle, the set wins.
- R9: irq_sf is the single flag AND its enable, and irq_df is the double flag AND its enable, both as levels.
- R10: irq_cmd is cmd_done AND the command-complete interrupt enable.
- R11: The first real fault loads cap_addr, cap_data and cap_dbl and sets cap_held. While the flag of the captured kind stays set, later faults of the same kind leave the capture unchanged. Once software clears that flag, the next real fault is captured.
- R12: A real double fault overwrites a held single-fault capture and sets cap_dbl=1. A held double capture is never overwritten by a single fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | One array read completed this cycle |
| rd_sgl | input | 1 | Decoder found a correctable single-bit fault |
| rd_dbl | input | 1 | Decoder found an uncorrectable double-bit fault |
| rd_addr | input | ADDR_W | Address of the read |
| rd_data | input | DATA_W | Data of the read |
| cmd_done | input | 1 | Command-complete flag from the sequencer |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 enables, 2 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cap_held | output | 1 | Capture register holds a fault |
| cap_dbl | output | 1 | Captured fault was double-bit |
| cap_addr | output | ADDR_W | Captured read address |
| cap_data | output | DATA_W | Captured read data |
| irq_sf | output | 1 | Single-fault interrupt |
| irq_df | output | 1 | Double-fault interrupt |
| irq_cmd | output | 1 | Command-complete interrupt |

## Verification
The bench targets reads that carry both fault indications. A design without the double-over-single priority would raise the single flag or capture the read as a single fault. It also combines injection with ignore-single and with a real fault on the same read: a design that let injection load the capture register, or let the ignore control swallow injected faults, shows the wrong cap_held or flag. It checks that a held capture survives a second fault, gives way to a later double fault, and reloads after its flag is cleared, which catches register overwrite or missing release. A clear written in the same cycle as a setting read catches a design where the clear wins.

// File: rtl/ecc_flag_pkg.sv
package ecc_flag_pkg;
  localparam int SEL_W  = 2;
  localparam int BYTE_W = 8;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_EN   = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // control byte bit positions
  localparam int CT_CCIE = 7;
  localparam int CT_IGN  = 4;
  localparam int CT_FDF  = 1;
  localparam int CT_FSF  = 0;
  // enable and status byte bit positions (shared layout)
  localparam int K_DBL = 1;
  localparam int K_SGL = 0;
  localparam int NKIND = 2;

  typedef struct packed {
    logic cc_ie;
    logic ign_sf;
    logic force_df;
    logic force_sf;
    logic df_ie;
    logic sf_ie;
  } ctrl_t;
endpackage

// File: rtl/ecc_cfg_regs.sv
module ecc_cfg_regs
  import ecc_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output logic [BYTE_W-1:0] ctrl_byte,
  output logic [BYTE_W-1:0] en_byte
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_CTRL) begin
        ctrl_q.cc_ie    <= wr_data[CT_CCIE];
        ctrl_q.ign_sf   <= wr_data[CT_IGN];
        ctrl_q.force_df <= wr_data[CT_FDF];
        ctrl_q.force_sf <= wr_data[CT_FSF];
      end
      if (wr_sel == SEL_EN) begin
        ctrl_q.df_ie <= wr_data[K_DBL];
        ctrl_q.sf_ie <= wr_data[K_SGL];
      end
    end
  end

  always_comb begin
    ctrl_byte          = '0;
    ctrl_byte[CT_CCIE] = ctrl_q.cc_ie;
    ctrl_byte[CT_IGN]  = ctrl_q.ign_sf;
    ctrl_byte[CT_FDF]  = ctrl_q.force_df;
    ctrl_byte[CT_FSF]  = ctrl_q.force_sf;
    en_byte            = '0;
    en_byte[K_DBL]     = ctrl_q.df_ie;
    en_byte[K_SGL]     = ctrl_q.sf_ie;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/ecc_fault_classify.sv
module ecc_fault_classify
  import ecc_flag_pkg::*;
(
  input  logic             rd_valid,
  input  logic             rd_sgl,
  input  logic             rd_dbl,
  input  logic             ign_sf,
  input  logic             force_sf,
  input  logic             force_df,
  output logic [NKIND-1:0] real_hit,
  output logic [NKIND-1:0] flag_set
);
  always_comb begin
    real_hit[K_DBL] = rd_valid & rd_dbl;
    // a double fault on the same read masks the single indication
    real_hit[K_SGL] = rd_valid & rd_sgl & ~rd_dbl & ~ign_sf;
    flag_set[K_DBL] = real_hit[K_DBL] | (rd_valid & force_df);
    flag_set[K_SGL] = real_hit[K_SGL] | (rd_valid & force_sf);
  end
endmodule

// File: rtl/ecc_fault_flags.sv
module ecc_fault_flags
  import ecc_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NKIND-1:0] set_i,
  input  logic [NKIND-1:0] clr_i,
  output logic [NKIND-1:0] flag_o
);
  for (genvar k = 0; k < NKIND; k++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[k]) q <= 1'b1;
      else if (clr_i[k]) q <= 1'b0;
    end
    assign flag_o[k] = q;
  end
endmodule

// File: rtl/ecc_capture.sv
module ecc_capture
  import ecc_flag_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NKIND-1:0] real_hit,
  input  logic [NKIND-1:0] clr_i,
  input  logic [AW-1:0]    rd_addr,
  input  logic [DW-1:0]    rd_data,
  output logic             held,
  output logic             is_dbl,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    data_q
);
  logic release_c, held_eff, load_c;

  always_comb begin
    release_c = held & (is_dbl ? clr_i[K_DBL] : clr_i[K_SGL]);
    held_eff  = held & ~release_c;
    load_c    = (real_hit[K_DBL] & (~held_eff | ~is_dbl))
              | (real_hit[K_SGL] & ~held_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= 1'b0;
      is_dbl <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (load_c) begin
      held   <= 1'b1;
      is_dbl <= real_hit[K_DBL];
      addr_q <= rd_addr;
      data_q <= rd_data;
    end else if (release_c) begin
      held   <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_fault_ctrl.sv
module ecc_fault_ctrl
  import ecc_flag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic              rd_sgl,
  input  logic              rd_dbl,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              cmd_done,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              cap_held,
  output logic              cap_dbl,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic              irq_sf,
  output logic              irq_df,
  output logic              irq_cmd
);
  ctrl_t             ctrl;
  logic [BYTE_W-1:0] ctrl_byte, en_byte, stat_byte;
  logic [NKIND-1:0]  real_hit, flag_set, flag_clr, flags;
  logic              sf_flag, df_flag, sf_clr, force_sf, force_df, ign_sf, df_ie;

  ecc_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_sel(reg_sel),
    .wr_data(reg_wdata), .ctrl(ctrl), .ctrl_byte(ctrl_byte), .en_byte(en_byte)
  );

  assign force_sf = ctrl.force_sf;
  assign force_df = ctrl.force_df;
  assign ign_sf   = ctrl.ign_sf;
  assign df_ie    = ctrl.df_ie;

  ecc_fault_classify u_cls (
    .rd_valid(rd_valid), .rd_sgl(rd_sgl), .rd_dbl(rd_dbl),
    .ign_sf(ign_sf), .force_sf(force_sf), .force_df(force_df),
    .real_hit(real_hit), .flag_set(flag_set)
  );

  assign flag_clr = (reg_we && reg_sel == SEL_STAT) ? reg_wdata[NKIND-1:0] : '0;
  assign sf_clr   = flag_clr[K_SGL];

  ecc_fault_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr), .flag_o(flags)
  );

  assign sf_flag = flags[K_SGL];
  assign df_flag = flags[K_DBL];

  ecc_capture #(.AW(ADDR_W), .DW(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .real_hit(real_hit), .clr_i(flag_clr),
    .rd_addr(rd_addr), .rd_data(rd_data), .held(cap_held), .is_dbl(cap_dbl),
    .addr_q(cap_addr), .data_q(cap_data)
  );

  always_comb begin
    stat_byte              = '0;
    stat_byte[NKIND-1:0]   = flags;
    case (reg_sel)
      SEL_CTRL: reg_rdata = ctrl_byte;
      SEL_EN:   reg_rdata = en_byte;
      SEL_STAT: reg_rdata = stat_byte;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_sf  = sf_flag & ctrl.sf_ie;
  assign irq_df  = df_flag & df_ie;
  assign irq_cmd = cmd_done & ctrl.cc_ie;
endmodule

// File: rtl/ecc_fault_ctrl_chk.sv
module ecc_fault_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_sgl,
  input logic          rd_dbl,
  input logic          ign_sf,
  input logic          force_sf,
  input logic          force_df,
  input logic          sf_flag,
  input logic          df_flag,
  input logic          sf_clr,
  input logic          df_ie,
  input logic          irq_df,
  input logic          cap_held,
  input logic [AW-1:0] cap_addr,
  input logic [DW-1:0] cap_data
);
  AST_IGN_NO_SF: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_sgl && ign_sf && !force_sf && !sf_flag |=> !sf_flag); // R4
  AST_DBL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_dbl |=> df_flag); // R5
  AST_DBL_MASKS_SGL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_dbl && !force_sf && !sf_clr |=> sf_flag == $past(sf_flag)); // R5
  AST_FORCE_DF: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && force_df |=> df_flag); // R6
  AST_FORCE_SF: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && force_sf |=> sf_flag); // R7
  AST_NO_READ_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid && !sf_flag |=> !sf_flag); // R8
  AST_IRQ_DF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_df |-> df_ie && df_flag); // R9
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_held && !rd_valid |=> $stable(cap_addr) && $stable(cap_data)); // R11
endmodule

bind ecc_fault_ctrl ecc_fault_ctrl_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_sgl(rd_sgl), .rd_dbl(rd_dbl),
  .ign_sf(ign_sf), .force_sf(force_sf), .force_df(force_df),
  .sf_flag(sf_flag), .df_flag(df_flag), .sf_clr(sf_clr), .df_ie(df_ie),
  .irq_df(irq_df), .cap_held(cap_held), .cap_addr(cap_addr), .cap_data(cap_data)
);

// File: tb/ecc_fault_ctrl_tb.sv
`timescale 1ns/1ps
module ecc_fault_ctrl_tb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NV = 12;
  // {ctrl[7:0], sgl, dbl, exp_sf, exp_df, exp_cap}
  localparam logic [12:0] VEC [NV] = '{
    {8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 real single
    {8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 real double
    {8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 both indications
    {8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 ignored single
    {8'h10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R4 ignore leaves double
    {8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R6 forced double
    {8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 forced single
    {8'h11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 forced single beats ignore
    {8'h03, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R6 both forced
    {8'h02, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R6 forced double plus real single
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 clean read
    {8'h01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}   // R7 forced single plus real double
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_valid = 0, rd_sgl = 0, rd_dbl = 0, cmd_done = 0, reg_we = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data = '0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic cap_held, cap_dbl, irq_sf, irq_df, irq_cmd;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ecc_fault_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_sgl(rd_sgl), .rd_dbl(rd_dbl),
    .rd_addr(rd_addr), .rd_data(rd_data), .cmd_done(cmd_done), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cap_held(cap_held), .cap_dbl(cap_dbl), .cap_addr(cap_addr), .cap_data(cap_data),
    .irq_sf(irq_sf), .irq_df(irq_df), .irq_cmd(irq_cmd)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_wdata = '0;
  endtask

  task automatic rdreg(input logic [1:0] sel, output logic [7:0] d);
    reg_sel = sel; #1; d = reg_rdata;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] dt, input logic s, input logic db);
    @(negedge clk);
    rd_valid = 1; rd_addr = a; rd_data = dt; rd_sgl = s; rd_dbl = db;
    @(negedge clk);
    rd_valid = 0; rd_sgl = 0; rd_dbl = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    rdreg(0, v); chk("R2 ctrl reset", v, 8'h00);
    rdreg(1, v); chk("R1 enable reset", v, 8'h00);
    rdreg(2, v); chk("R8 status reset", v, 8'h00);
    chk("R11 capture empty at reset", cap_held, 0);
    chk("R9 irqs at reset", {irq_sf, irq_df, irq_cmd}, 3'b000);

    wr(1, 8'hFF); rdreg(1, v); chk("R1 enable unused bits read 0", v, 8'h03);
    wr(0, 8'hFF); rdreg(0, v); chk("R2 ctrl unused bits read 0", v, 8'h93);
    wr(0, 8'h00);

    // vector table walk, both enables on
    for (int i = 0; i < NV; i++) begin
      logic [12:0] e;
      e = VEC[i];
      wr(0, e[12:5]);
      wr(2, 8'h03);
      rd(AW'(16'h0100 + i), DW'(32'hA500_0000 + i), e[4], e[3]);
      rdreg(2, v);
      chk($sformatf("R3/R5 vec%0d flags", i), v, {6'b0, e[1], e[2]});
      chk($sformatf("R9 vec%0d irqs", i), {irq_df, irq_sf}, {e[1], e[2]});
      chk($sformatf("R6/R7 vec%0d capture", i), cap_held, e[0]);
      if (e[0]) begin
        chk($sformatf("R11 vec%0d addr", i), cap_addr, AW'(16'h0100 + i));
        chk($sformatf("R5 vec%0d kind", i), cap_dbl, e[3]);
      end
      wr(0, 8'h00);
    end
    wr(2, 8'h03);

    // R2 force bit persists across reads until 0 written
    wr(0, 8'h02);
    rd(16'h1, 32'h1, 0, 0); wr(2, 8'h03); rd(16'h2, 32'h2, 0, 0);
    rdreg(0, v); chk("R2 force persists", v, 8'h02);
    rdreg(2, v); chk("R6 force again", v, 8'h02);
    wr(0, 8'h00); wr(2, 8'h03); rd(16'h3, 32'h3, 0, 0);
    rdreg(2, v); chk("R2 force cleared by write 0", v, 8'h00);

    // R3 fault inputs without rd_valid do nothing
    @(negedge clk); rd_sgl = 1; rd_dbl = 1; @(negedge clk); rd_sgl = 0; rd_dbl = 0;
    rdreg(2, v); chk("R3 no strobe no flag", v, 8'h00);
    chk("R3 no strobe no capture", cap_held, 0);

    // R9 enables gate interrupts
    wr(1, 8'h00); rd(16'h10, 32'h10, 0, 1);
    chk("R9 irq_df masked", irq_df, 0);
    wr(1, 8'h02); chk("R9 irq_df unmasked", irq_df, 1);
    chk("R9 irq_sf stays low", irq_sf, 0);
    wr(2, 8'h03);

    // R10 command complete
    cmd_done = 1; #1; chk("R10 cmd irq masked", irq_cmd, 0);
    wr(0, 8'h80); chk("R10 cmd irq", irq_cmd, 1);
    cmd_done = 0; #1; chk("R10 cmd irq follows flag", irq_cmd, 0);
    wr(0, 8'h00);

    // R8 sticky and write-1-clear
    rd(16'h20, 32'h20, 1, 0); rd(16'h21, 32'h21, 0, 1);
    wr(2, 8'h00); rdreg(2, v); chk("R8 write 0 no effect", v, 8'h03);
    wr(2, 8'h01); rdreg(2, v); chk("R8 clear single only", v, 8'h02);
    wr(2, 8'h03);
    // R8 set wins over clear in the same cycle
    @(negedge clk);
    reg_we = 1; reg_sel = 2; reg_wdata = 8'h01;
    rd_valid = 1; rd_sgl = 1; rd_addr = 16'h30; rd_data = 32'h30;
    @(negedge clk);
    reg_we = 0; rd_valid = 0; rd_sgl = 0;
    rdreg(2, v); chk("R8 set beats clear", v, 8'h01);
    wr(2, 8'h03);

    // R11 capture holds first fault, reloads after clear
    rd(16'h40, 32'hC0DE0040, 1, 0);
    rd(16'h41, 32'hC0DE0041, 1, 0);
    chk("R11 first kept addr", cap_addr, 16'h40);
    chk("R11 first kept data", cap_data, 32'hC0DE0040);
    wr(2, 8'h01); chk("R11 released", cap_held, 0);
    rd(16'h42, 32'hC0DE0042, 1, 0);
    chk("R11 reload after clear", cap_addr, 16'h42);

    // R12 double upgrades a held single; single never displaces double
    rd(16'h50, 32'h50, 0, 1);
    chk("R12 upgrade addr", cap_addr, 16'h50);
    chk("R12 upgrade kind", cap_dbl, 1);
    rd(16'h51, 32'h51, 1, 0);
    chk("R12 double kept", cap_addr, 16'h50);
    rd(16'h52, 32'h52, 0, 1);
    chk("R11 double not overwritten", cap_addr, 16'h50);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule